// File: doc/BRIEF.md
# Boot-Aware External Chip Select Decoder

This block turns a 32-bit bus address into seven active-low external chip selects, numbered 0 to 6. Each select has its own base address, don't-care mask and control word, which software reaches through a small register port. The controller raises a transfer strobe for each external access. While the strobe is high, the block holds the winning select low and reports that select's data port size and the byte lanes that carry data, for a downstream bus sizer.

Out of reset the block is in boot mode. Select 0 answers every external access, whatever the address, and selects 1 to 6 stay quiet. The port size of select 0 is strapped from two data-bus pins that are sampled while reset is held. When software writes a 1 to the valid bit of select 0, the block moves to normal mode. From then on, every select decodes only its programmed window. Normal mode lasts until the next reset.

There are two state machines. The mode machine has states MODE_BOOT and MODE_NORMAL. Its only transition, BOOT to NORMAL, is taken on a register write that sets the valid bit of select 0, and reset is the only way back. The transfer machine has states XF_IDLE and XF_HOLD. It goes from IDLE to HOLD when the strobe is sampled high, which captures the decode. It goes from HOLD to IDLE when the strobe is sampled low, which releases every select. It stays in HOLD while the strobe remains high.

Top module: `ext_cs_decoder`

## Requirements
- R1: After reset, with a strap other than 00, every transfer asserts select 0 (cs_n = 7'h7E) whatever the address.
- R2: In boot mode, selects 1 to 6 stay high, even when they are valid and their window matches.
- R3: After a write of 1 to control bit 0 of select 0, select 0 asserts only inside its own window, and selects 1 to 6 decode their windows.
- R4: Once normal mode is entered, clearing the valid bit of select 0 does not restore the catch-all decode: an access that matches no valid window asserts no select.
- R5: strap_pins is sampled only while rst_n is low. Its value loads control bits [2:1] of select 0, where the size code is 00 = 32-bit, 01 = 16-bit, 10 = 8-bit and 11 = 32-bit. Later changes of the pins have no effect.
- R6: Strap 00 marks an internal boot device. Control bit 3 of select 0 then reads 1, and select 0 never asserts, in either mode.
- R7: Register offsets at or above 84 read zero. Base and mask bits [15:0] read zero, and control bits other than [2:0] read zero, except bit 3 of select 0.
- R8: A valid select matches when ((addr ^ base) & ~mask) is zero over bits [31:16]. Address bits [15:0] never affect the match.
- R9: When several eligible selects match, only the lowest-numbered one asserts.
- R10: cs_n, port_size and lane_en change on the first rising edge at which the strobe is sampled high. They then hold the captured decode while the strobe stays high, even if the address changes. On the first edge at which the strobe is sampled low, all selects go high, lane_en goes to 0 and port_size goes to 00.
- R11: Select i has its registers at byte offsets 12*i (base), 12*i+4 (mask) and 12*i+8 (control, with bit 0 = valid and bits [2:1] = size). Writes are visible on reads from the next cycle on.
- R12: lane_en gives the active data byte lanes, with bit 3 = D[31:24]: 4'b1111 for 32-bit, 4'b1100 for 16-bit, 4'b1000 for 8-bit, and 4'b0000 when no select asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pins | input | 2 | Boot size strap, sampled while reset is held |
| bus_strobe | input | 1 | High for the duration of an external transfer |
| bus_addr | input | 32 | Transfer address |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | Register write when high |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| cs_n | output | 7 | Active-low chip selects, bit i is select i |
| port_size | output | 2 | Size code of the asserted select |
| lane_en | output | 4 | Active byte lanes, bit 3 = D[31:24] |

## Verification
Chip select, size and lane outputs are due one rising edge after the strobe is first sampled high. The release is due one edge after the strobe is sampled low. Register reads settle in the same cycle as the offset, and a write shows up in reads from the following cycle. The bench drives every input on the falling edge and samples 1 ns after the rising edge at which a result is due. On the cycles after the first, it flips the upper address bits to show that the captured decode does not change. Each strap code gets its own reset, so that the reset-time sampling and the sticky mode change can be checked.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    typedef enum logic {
        MODE_BOOT,
        MODE_NORMAL
    } boot_mode_e;

    typedef enum logic {
        XF_IDLE,
        XF_HOLD
    } xfer_state_e;

    localparam logic [1:0] PS_32  = 2'b00;
    localparam logic [1:0] PS_16  = 2'b01;
    localparam logic [1:0] PS_8   = 2'b10;
    localparam logic [1:0] PS_32B = 2'b11;

    // Narrow ports sit on the high-order byte lanes.
    function automatic logic [3:0] lanes_for(input logic [1:0] sz);
        logic [3:0] l;
        unique case (sz)
            PS_16:   l = 4'b1100;
            PS_8:    l = 4'b1000;
            default: l = 4'b1111;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/ecs_regfile.sv
module ecs_regfile #(
    parameter int NUM_CS    = 7,
    parameter int ADDR_W    = 32,
    parameter int REG_AW    = 8,
    parameter int GRAN_BITS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     strap,
    input  logic                           reg_en,
    input  logic                           reg_we,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    output logic [NUM_CS-1:0][ADDR_W-1:0]  base_o,
    output logic [NUM_CS-1:0][ADDR_W-1:0]  mask_o,
    output logic [NUM_CS-1:0]              valid_o,
    output logic [NUM_CS-1:0][1:0]         size_o,
    output logic                           boot_internal,
    output logic                           cs0_valid_set
);
    localparam int HI_W   = ADDR_W - GRAN_BITS;
    localparam int STRIDE = 12;

    logic [NUM_CS-1:0][31:0] rd_part;
    logic                    wr;

    assign wr = reg_en && reg_we;

    // The boot flag is latched while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_internal <= (strap == 2'b00);
    end

    assign cs0_valid_set = wr && (reg_addr == REG_AW'(8)) && reg_wdata[0];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        localparam int OFF = STRIDE * i;
        logic [HI_W-1:0] base_hi;
        logic [HI_W-1:0] mask_hi;
        logic            valid_q;
        logic [1:0]      size_q;
        logic            hit_b, hit_m, hit_c;
        logic            flag;

        assign hit_b = (reg_addr == REG_AW'(OFF));
        assign hit_m = (reg_addr == REG_AW'(OFF + 4));
        assign hit_c = (reg_addr == REG_AW'(OFF + 8));
        assign flag  = (i == 0) ? boot_internal : 1'b0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_hi <= '0;
                mask_hi <= '0;
                valid_q <= 1'b0;
                size_q  <= (i == 0) ? strap : PS_DEFAULT;
            end else if (wr) begin
                if (hit_b) base_hi <= reg_wdata[31:GRAN_BITS];
                if (hit_m) mask_hi <= reg_wdata[31:GRAN_BITS];
                if (hit_c) begin
                    valid_q <= reg_wdata[0];
                    size_q  <= reg_wdata[2:1];
                end
            end
        end

        assign base_o[i]  = {base_hi, {GRAN_BITS{1'b0}}};
        assign mask_o[i]  = {mask_hi, {GRAN_BITS{1'b0}}};
        assign valid_o[i] = valid_q;
        assign size_o[i]  = size_q;

        always_comb begin
            rd_part[i] = '0;
            if (hit_b) rd_part[i] = {base_hi, {GRAN_BITS{1'b0}}};
            if (hit_m) rd_part[i] = {mask_hi, {GRAN_BITS{1'b0}}};
            if (hit_c) rd_part[i] = {28'd0, flag, size_q, valid_q};
        end
    end

    localparam logic [1:0] PS_DEFAULT = 2'b00;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) reg_rdata = reg_rdata | rd_part[i];
    end

endmodule

// File: rtl/ecs_match.sv
module ecs_match #(
    parameter int NUM_CS    = 7,
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 16
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_CS-1:0][ADDR_W-1:0]  base,
    input  logic [NUM_CS-1:0][ADDR_W-1:0]  mask,
    input  logic [NUM_CS-1:0]              valid,
    input  logic [NUM_CS-1:0][1:0]         size,
    input  ecs_pkg::boot_mode_e            mode,
    input  logic                           boot_internal,
    output logic [NUM_CS-1:0]              sel,
    output logic [1:0]                     sel_size
);
    import ecs_pkg::*;

    logic [NUM_CS-1:0] window_hit;
    logic [NUM_CS-1:0] eligible;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_win
        assign window_hit[i] =
            (((addr[ADDR_W-1:GRAN_BITS] ^ base[i][ADDR_W-1:GRAN_BITS])
              & ~mask[i][ADDR_W-1:GRAN_BITS]) == '0);
        if (i == 0) begin : g_boot
            assign eligible[i] = !boot_internal &&
                ((mode == MODE_BOOT) || (valid[i] && window_hit[i]));
        end else begin : g_other
            assign eligible[i] = (mode == MODE_NORMAL) && valid[i] && window_hit[i];
        end
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        sel      = '0;
        sel_size = PS_32;
        for (int i = 0; i < NUM_CS; i++) begin
            if (eligible[i] && !found) begin
                sel[i]   = 1'b1;
                sel_size = size[i];
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecs_mode_fsm.sv
module ecs_mode_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs0_valid_set,
    output ecs_pkg::boot_mode_e mode
);
    import ecs_pkg::*;

    boot_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BOOT:   if (cs0_valid_set) state_d = MODE_NORMAL;
            MODE_NORMAL: state_d = MODE_NORMAL;
            default:     state_d = MODE_BOOT;
        endcase
    end

    assign mode = state_q;

endmodule

// File: rtl/ecs_xfer_fsm.sv
module ecs_xfer_fsm #(
    parameter int NUM_CS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [NUM_CS-1:0] sel,
    input  logic [1:0]        sel_size,
    output logic [NUM_CS-1:0] cs_n,
    output logic [1:0]        port_size,
    output logic [3:0]        lane_en
);
    import ecs_pkg::*;

    xfer_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (strobe)  state_d = XF_HOLD;
            XF_HOLD: if (!strobe) state_d = XF_IDLE;
            default: state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n      <= '1;
            port_size <= PS_32;
            lane_en   <= 4'b0000;
        end else begin
            unique case (state_q)
                XF_IDLE: begin
                    if (strobe) begin
                        cs_n      <= ~sel;
                        port_size <= (|sel) ? sel_size : PS_32;
                        lane_en   <= (|sel) ? lanes_for(sel_size) : 4'b0000;
                    end
                end
                XF_HOLD: begin
                    if (!strobe) begin
                        cs_n      <= '1;
                        port_size <= PS_32;
                        lane_en   <= 4'b0000;
                    end
                end
                default: cs_n <= '1;
            endcase
        end
    end

endmodule

// File: rtl/ext_cs_decoder.sv
module ext_cs_decoder #(
    parameter int NUM_CS    = 7,
    parameter int ADDR_W    = 32,
    parameter int REG_AW    = 8,
    parameter int GRAN_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_pins,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CS-1:0] cs_n,
    output logic [1:0]        port_size,
    output logic [3:0]        lane_en
);
    import ecs_pkg::*;

    logic [NUM_CS-1:0][ADDR_W-1:0] base_w;
    logic [NUM_CS-1:0][ADDR_W-1:0] mask_w;
    logic [NUM_CS-1:0]             valid_w;
    logic [NUM_CS-1:0][1:0]        size_w;
    logic                          boot_internal;
    logic                          cs0_valid_set;
    boot_mode_e                    mode_q;
    logic [NUM_CS-1:0]             sel_w;
    logic [1:0]                    sel_size_w;

    ecs_regfile #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .GRAN_BITS(GRAN_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .strap(strap_pins),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_o(base_w), .mask_o(mask_w), .valid_o(valid_w), .size_o(size_w),
        .boot_internal(boot_internal), .cs0_valid_set(cs0_valid_set)
    );

    ecs_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .cs0_valid_set(cs0_valid_set), .mode(mode_q)
    );

    ecs_match #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)
    ) u_match (
        .addr(bus_addr), .base(base_w), .mask(mask_w), .valid(valid_w),
        .size(size_w), .mode(mode_q), .boot_internal(boot_internal),
        .sel(sel_w), .sel_size(sel_size_w)
    );

    ecs_xfer_fsm #(.NUM_CS(NUM_CS)) u_xfer (
        .clk(clk), .rst_n(rst_n), .strobe(bus_strobe),
        .sel(sel_w), .sel_size(sel_size_w),
        .cs_n(cs_n), .port_size(port_size), .lane_en(lane_en)
    );

endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
    parameter int NUM_CS = 7,
    parameter int REG_AW = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_strobe,
    input logic [NUM_CS-1:0]   cs_n,
    input logic [3:0]          lane_en,
    input logic [REG_AW-1:0]   reg_addr,
    input logic [31:0]         reg_rdata,
    input ecs_pkg::boot_mode_e mode,
    input logic                boot_internal
);
    import ecs_pkg::*;

    assert_boot_others_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BOOT) |-> (&cs_n[NUM_CS-1:1]));

    assert_normal_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL) |=> (mode == MODE_NORMAL));

    assert_internal_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_internal |-> cs_n[0]);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= REG_AW'(12 * NUM_CS)) |-> (reg_rdata == 32'd0));

    assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> ((&cs_n) && (lane_en == 4'b0000)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && $past(bus_strobe)) |=> $stable(cs_n));

    assert_lanes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> (lane_en == 4'b0000));

endmodule

bind ext_cs_decoder ecs_checker #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .cs_n(cs_n),
    .lane_en(lane_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .mode(mode_q), .boot_internal(boot_internal)
);

// File: tb/ext_cs_decoder_test.sv
module ext_cs_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_pins = 2'b01;
    logic        bus_strobe = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  cs_n;
    logic [1:0]  port_size;
    logic [3:0]  lane_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ext_cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins),
        .bus_strobe(bus_strobe), .bus_addr(bus_addr),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cs_n(cs_n), .port_size(port_size), .lane_en(lane_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_pins = strap;
        bus_strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        strap_pins = ~strap;   // changes after reset must be ignored
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 check(tag, reg_rdata, exp);
        reg_en = 1'b0;
    endtask

    // One transfer: results are due one edge after the strobe is sampled high
    // and must hold while the address moves; release is due one edge after low.
    task automatic access(input string tag, input logic [31:0] a, input int hold,
                          input logic [6:0] exp_cs, input logic [1:0] exp_sz,
                          input logic [3:0] exp_ln);
        @(negedge clk);
        bus_addr = a;
        bus_strobe = 1'b1;
        for (int c = 0; c < hold; c++) begin
            @(posedge clk);
            #1;
            check({tag, " cs_n"}, 32'(cs_n), 32'(exp_cs));
            check({tag, " size"}, 32'(port_size), 32'(exp_sz));
            check({tag, " lanes"}, 32'(lane_en), 32'(exp_ln));
            @(negedge clk);
            bus_addr = a ^ 32'hFFFF_0000;
        end
        bus_strobe = 1'b0;
        @(posedge clk);
        #1;
        check({tag, " R10 release cs_n"}, 32'(cs_n), 32'h7F);
        check({tag, " R10 release lanes"}, 32'(lane_en), 32'h0);
    endtask

    task automatic t_boot_catch_all;
        do_reset(2'b01);
        #1 check("R1 reset cs_n", 32'(cs_n), 32'h7F);
        reg_check("R5 ctrl0 strap 01", 8'd8, 32'h2);
        access("R1 boot any addr", 32'hDEAD_BEEF, 1, 7'h7E, 2'b01, 4'b1100);
        access("R1 boot other addr", 32'h0000_0004, 1, 7'h7E, 2'b01, 4'b1100);
    endtask

    task automatic t_boot_others_off;
        reg_write(8'd36, 32'h2000_0000);        // CS3 base
        reg_write(8'd40, 32'h0000_0000);        // CS3 mask
        reg_write(8'd44, 32'h0000_0001);        // CS3 valid, 32-bit
        access("R2 boot CS3 blocked", 32'h2000_0000, 1, 7'h7E, 2'b01, 4'b1100);
    endtask

    task automatic t_unlock;
        reg_write(8'd0, 32'h0000_0000);
        reg_write(8'd4, 32'h000F_0000);
        reg_write(8'd8, 32'h0000_0005);         // valid, 8-bit
        reg_check("R11 ctrl0 readback", 8'd8, 32'h5);
        reg_check("R11 mask0 readback", 8'd4, 32'h000F_0000);
        access("R3 CS0 in window", 32'h000A_1234, 1, 7'h7E, 2'b10, 4'b1000);
        access("R3 CS3 decodes", 32'h2000_1234, 1, 7'h77, 2'b00, 4'b1111);
        access("R3 outside all", 32'h5000_0000, 1, 7'h7F, 2'b00, 4'b0000);
    endtask

    task automatic t_priority_mask;
        reg_write(8'd12, 32'h2000_0000);
        reg_write(8'd16, 32'h0FFF_0000);
        reg_write(8'd20, 32'h0000_0003);        // CS1 valid, 16-bit
        access("R9 CS1 beats CS3", 32'h2000_0000, 1, 7'h7D, 2'b01, 4'b1100);
        access("R8 masked top", 32'h2FFF_FFFF, 1, 7'h7D, 2'b01, 4'b1100);
        access("R8 beyond mask", 32'h3000_0000, 1, 7'h7F, 2'b00, 4'b0000);
    endtask

    task automatic t_sticky;
        reg_write(8'd8, 32'h0000_0000);
        access("R4 no catch-all", 32'h0000_0000, 1, 7'h7F, 2'b00, 4'b0000);
        access("R4 CS1 still", 32'h2100_0000, 1, 7'h7D, 2'b01, 4'b1100);
    endtask

    task automatic t_reserved;
        reg_check("R7 offset 84", 8'd84, 32'h0);
        reg_check("R7 offset 252", 8'd252, 32'h0);
        reg_write(8'd24, 32'hFFFF_FFFF);
        reg_write(8'd32, 32'hFFFF_FFFF);
        reg_check("R7 base2 low bits", 8'd24, 32'hFFFF_0000);
        reg_check("R7 ctrl2 unused bits", 8'd32, 32'h7);
        reg_check("R11 base1 stride", 8'd12, 32'h2000_0000);
    endtask

    task automatic t_hold_timing;
        access("R10 long hold", 32'h2000_0000, 4, 7'h7D, 2'b01, 4'b1100);
    endtask

    task automatic t_internal_boot;
        do_reset(2'b00);
        reg_check("R6 ctrl0 strap 00", 8'd8, 32'h8);
        access("R6 boot silent", 32'h1234_0000, 1, 7'h7F, 2'b00, 4'b0000);
        reg_write(8'd4, 32'hFFFF_0000);
        reg_write(8'd8, 32'h0000_0001);
        reg_write(8'd48, 32'h4000_0000);
        reg_write(8'd56, 32'h0000_0001);
        access("R6 normal silent", 32'h0000_0000, 1, 7'h7F, 2'b00, 4'b0000);
        access("R3 CS4 after unlock", 32'h4000_0000, 1, 7'h6F, 2'b00, 4'b1111);
    endtask

    task automatic t_strap_codes;
        do_reset(2'b10);
        reg_check("R5 ctrl0 strap 10", 8'd8, 32'h4);
        access("R12 8-bit lanes", 32'h8000_0000, 1, 7'h7E, 2'b10, 4'b1000);
        do_reset(2'b11);
        reg_check("R5 ctrl0 strap 11", 8'd8, 32'h6);
        access("R12 32-bit lanes", 32'h0001_0000, 1, 7'h7E, 2'b11, 4'b1111);
    endtask

    initial begin
        t_boot_catch_all();
        t_boot_others_off();
        t_unlock();
        t_priority_mask();
        t_sticky();
        t_reserved();
        t_hold_timing();
        t_internal_boot();
        t_strap_codes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule